// File: doc/BRIEF.md
# Sequential 32-by-16 Unsigned Divider with Up-Front Overflow Detection

This block divides an unsigned 32-bit dividend, given as an upper and a lower 16-bit word, by an unsigned 16-bit divisor. A restoring shift-subtract engine produces one quotient bit per clock. When it finishes, the quotient sits in the lower result word and the remainder in the upper result word.

Before any iteration starts, the block compares the divisor with the dividend's upper word. If the divisor is not strictly greater, the quotient cannot fit in 16 bits. In that case the block skips the iteration, raises an overflow flag, and returns a saturated all-ones quotient. A zero divisor falls into the same case.

Control is a three-state machine:
- IDLE waits for a start pulse.
- RUN performs the shift-subtract steps.
- FIN presents `done` for one cycle.

The named transitions are:
- accept_divide: IDLE to RUN, on start with no overflow.
- accept_saturate: IDLE to FIN, on start with overflow.
- step: RUN to RUN, while steps remain.
- last_bit: RUN to FIN, after the final step.
- release: FIN to IDLE.

Top module: `ldiv_unit`

## Requirements
- R1: After reset, busy, done and ovf are 0, and quo_lo and rem_hi are 0.
- R2: A start accepted in IDLE sets ovf to 1 exactly when dvsr_in <= hi_in, compared as unsigned 16-bit values. This includes dvsr_in = 0. Otherwise ovf is set to 0.
- R3: Without overflow, when done is high, quo_lo = floor({hi_in,lo_in} / dvsr_in) and rem_hi = {hi_in,lo_in} mod dvsr_in. Here hi_in forms bits 31:16 of the dividend.
- R4: With overflow, when done is high, quo_lo = 16'hFFFF and rem_hi equals the hi_in operand unchanged.
- R5: done is high for exactly one cycle. Counting the edge that accepted start as edge 0, done rises after edge 16 without overflow and after edge 0 with overflow. busy is high from acceptance through the done cycle and low in IDLE.
- R6: A start pulse while busy is high is ignored. The running operation's results and its done timing are unchanged, and no second operation follows.
- R7: ovf keeps its value until the next accepted start, which overwrites it. An overflowing operation followed by a valid one leaves ovf at 0.
- R8: The dividend 32'hF0F0_0F0F divided by 16'hF0F0 reports overflow. So does every operand pair where bit 15 of both hi_in and dvsr_in is set and dvsr_in <= hi_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled in IDLE |
| hi_in | input | 16 | Dividend bits 31:16 |
| lo_in | input | 16 | Dividend bits 15:0 |
| dvsr_in | input | 16 | Divisor |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion strobe |
| ovf | output | 1 | Overflow flag of the last accepted operation |
| quo_lo | output | 16 | Quotient, or 16'hFFFF on overflow |
| rem_hi | output | 16 | Remainder, or the upper dividend word on overflow |

## Verification
The hardest region to reach is the boundary where the divisor equals the upper dividend word or exceeds it by one. In the latter case the quotient is just below the saturation value and every one of the 16 steps subtracts near the top of the range. The stimulus targets these cases directly:
- divisor = hi_in and divisor = hi_in + 1;
- the all-ones dividend with the largest legal divisor;
- a sweep of patterns with bit 15 set in both the upper word and the divisor.

A second start pulse injected in the middle of a running division shows that the busy guard holds. The operation that follows an overflow confirms that the flag is cleared.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
    localparam int unsigned LDIV_W = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } ldiv_state_e;
endpackage

// File: rtl/ldiv_ovf_check.sv
module ldiv_ovf_check #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] hi_word,
    input  logic [W-1:0] divisor,
    output logic         too_big
);
    // quotient fits only when divisor is strictly above the upper word
    always_comb too_big = !(divisor > hi_word);
endmodule

// File: rtl/ldiv_step.sv
module ldiv_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    // rem_i < divisor holds, so trial < 2*divisor and diff[W] is a pure borrow
    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        diff  = trial - {1'b0, divisor};
        fits  = !diff[W];
        rem_o = fits ? diff[W-1:0] : trial[W-1:0];
        quo_o = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/ldiv_ctrl.sv
module ldiv_ctrl
    import ldiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        too_big,
    output ldiv_state_e state,
    output logic        accept,
    output logic        step_en,
    output logic        busy,
    output logic        done
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    ldiv_state_e state_nx;
    logic [CW-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            if (accept)       cnt_q <= '0;
            else if (step_en) cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions: accept_divide, accept_saturate, step, last_bit, release
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = too_big ? S_FIN : S_RUN;
            S_RUN:  if (cnt_q == LAST) state_nx = S_FIN;
            S_FIN:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        step_en = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            S_RUN:  step_en = 1'b1;
            S_FIN:  done    = 1'b1;
            default: busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldiv_unit.sv
module ldiv_unit
    import ldiv_pkg::*;
#(
    parameter int unsigned WIDTH = LDIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] hi_in,
    input  logic [WIDTH-1:0] lo_in,
    input  logic [WIDTH-1:0] dvsr_in,
    output logic             busy,
    output logic             done,
    output logic             ovf,
    output logic [WIDTH-1:0] quo_lo,
    output logic [WIDTH-1:0] rem_hi
);
    ldiv_state_e      state;
    logic             accept;
    logic             step_en;
    logic             too_big;
    logic [WIDTH-1:0] dvsr_q;
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] rem_nx;
    logic [WIDTH-1:0] quo_nx;
    logic             ovf_q;

    ldiv_ovf_check #(.W(WIDTH)) u_ovf (
        .hi_word (hi_in),
        .divisor (dvsr_in),
        .too_big (too_big)
    );

    ldiv_ctrl #(.W(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .too_big (too_big),
        .state   (state),
        .accept  (accept),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    ldiv_step #(.W(WIDTH)) u_step (
        .rem_i   (rem_q),
        .quo_i   (quo_q),
        .divisor (dvsr_q),
        .rem_o   (rem_nx),
        .quo_o   (quo_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvsr_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            ovf_q  <= 1'b0;
        end else if (accept) begin
            dvsr_q <= dvsr_in;
            rem_q  <= hi_in;
            ovf_q  <= too_big;
            quo_q  <= too_big ? '1 : lo_in;
        end else if (step_en) begin
            rem_q  <= rem_nx;
            quo_q  <= quo_nx;
        end
    end

    assign ovf    = ovf_q;
    assign quo_lo = quo_q;
    assign rem_hi = rem_q;
endmodule

// File: rtl/ldiv_unit_chk.sv
module ldiv_unit_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] hi_in,
    input logic [W-1:0] dvsr_in,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] quo_lo,
    input logic [W-1:0] rem_hi,
    input logic [W-1:0] dvsr_q
);
    a_r2_ovf_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (ovf == ($past(dvsr_in) <= $past(hi_in))));

    a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> (rem_hi < dvsr_q));

    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (quo_lo == '1));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r6_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(dvsr_q));

    a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && !busy) |=> $stable(ovf));
endmodule

bind ldiv_unit ldiv_unit_chk #(.W(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hi_in   (hi_in),
    .dvsr_in (dvsr_in),
    .busy    (busy),
    .done    (done),
    .ovf     (ovf),
    .quo_lo  (quo_lo),
    .rem_hi  (rem_hi),
    .dvsr_q  (dvsr_q)
);

// File: tb/ldiv_unit_bench.sv
`timescale 1ns/1ps
module ldiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] hi_in = '0;
    logic [15:0] lo_in = '0;
    logic [15:0] dvsr_in = '0;
    logic        busy, done, ovf;
    logic [15:0] quo_lo, rem_hi;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ldiv_unit u_ldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hi_in(hi_in), .lo_in(lo_in), .dvsr_in(dvsr_in),
        .busy(busy), .done(done), .ovf(ovf),
        .quo_lo(quo_lo), .rem_hi(rem_hi)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launch one division; inject_mid pulses start again while running
    task automatic run_div(input logic [15:0] h, input logic [15:0] l,
                           input logic [15:0] d, input bit inject_mid, input string tag);
        logic [31:0] dd;
        logic [15:0] eq, er;
        bit          eo;
        int          lat;
        dd = {h, l};
        eo = (d <= h);
        if (eo) begin eq = 16'hFFFF; er = h; end
        else begin eq = 16'(dd / {16'h0, d}); er = 16'(dd % {16'h0, d}); end
        @(negedge clk);
        hi_in = h; lo_in = l; dvsr_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R5 busy after accept"}, busy, 1);
        chk(ovf == eo, {tag, " R2 ovf decision"}, ovf, eo);
        lat = 1;
        while (!done && lat < 40) begin
            if (inject_mid && lat == 4) begin
                hi_in = 16'h0000; lo_in = 16'h0009; dvsr_in = 16'h0003; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == (eo ? 1 : 17), {tag, " R5 done latency"}, lat, eo ? 1 : 17);
        chk(quo_lo == eq, {tag, eo ? " R4 saturated quotient" : " R3 quotient"}, quo_lo, eq);
        chk(rem_hi == er, {tag, eo ? " R4 upper word kept" : " R3 remainder"}, rem_hi, er);
        chk(ovf == eo, {tag, " R7 ovf held at done"}, ovf, eo);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R5 done single cycle"}, done, 0);
        chk(busy == 1'b0, {tag, " R5 R6 idle after done"}, busy, 0);
        chk(quo_lo == eq && ovf == eo, {tag, " R7 results hold in idle"}, quo_lo, eq);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && ovf == 0, "R1 reset flags", {busy, done, ovf}, 0);
        chk(quo_lo == 0 && rem_hi == 0, "R1 reset results", {quo_lo, rem_hi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        run_div(16'h0000, 16'd100, 16'd7, 1'b0, "basic R3");
        run_div(16'h1234, 16'h5678, 16'h9ABC, 1'b0, "mixed R3");
        run_div(16'h0000, 16'h0005, 16'h0009, 1'b0, "small R3");
    endtask

    task automatic t_boundary();
        run_div(16'h4000, 16'h0000, 16'h4000, 1'b0, "equal R2");
        run_div(16'h4000, 16'hFFFF, 16'h4001, 1'b0, "plus one R2");
        run_div(16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0, "max legal R3");
        run_div(16'h0000, 16'h1234, 16'h0000, 1'b0, "zero divisor R2");
    endtask

    task automatic t_msb_sweep();
        run_div(16'hF0F0, 16'h0F0F, 16'hF0F0, 1'b0, "F0F0 R8");
        for (int i = 0; i < 8; i++) begin
            logic [15:0] h, d;
            h = 16'h8000 | 16'(i * 16'h0F11);
            d = 16'h8000 | 16'(i * 16'h0E01);
            run_div(h, 16'(i * 16'h1357), d, 1'b0, "msb sweep R8");
        end
    endtask

    task automatic t_busy_ignore();
        run_div(16'h0012, 16'h3456, 16'h0F00, 1'b1, "inject R6");
    endtask

    task automatic t_ovf_clear();
        run_div(16'h9000, 16'h0000, 16'h0001, 1'b0, "ovf first R7");
        run_div(16'h0001, 16'h0000, 16'h0100, 1'b0, "clear next R7");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_boundary();
        t_msb_sweep();
        t_busy_ignore();
        t_ovf_clear();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule